// File: doc/BRIEF.md
# Periodic Temperature Conversion Sequencer

This block paces the conversions of a digital thermal sensor. While the configuration mode bit selects normal operation, it asks an external converter for a new temperature sample once per fixed period. It takes each 11-bit two's complement result the converter returns and loads it into a 16-bit temperature register. Each result is worth 0.125 °C per least significant bit. On every completed conversion it also sends a single-cycle pulse that tells the threshold comparison logic to evaluate the new value.

When the mode bit selects shutdown, the block launches nothing and the temperature register keeps its last contents. Reset starts a conversion straight away, and so does every return from shutdown to normal mode. A valid flag tells readers whether the register holds a measured value yet. Register reads elsewhere in the chip do not touch this block, so a running conversion cannot be disturbed by them. The period is a parameter counted in clock cycles.

Top module: `temp_conv_sequencer`

## Requirements
- R1: While `rst_n` is low, at the following clock edge `conv_start_o`, `cmp_strobe_o` and `temp_valid_o` go to 0 and `temp_reg_o` goes to 16'h0000.
- R2: With `shutdown_i` = 0 (normal mode), the first clock edge after reset release raises `conv_start_o` for one cycle.
- R3: In normal mode, successive `conv_start_o` pulses are exactly `PERIOD_CYCLES` clock cycles apart.
- R4: A `conv_done_i` pulse during a conversion in flight loads `temp_reg_o` at that clock edge with the sample left-justified: bits [15:5] = `conv_sample_i` and bits [4:0] = 0. For example, sample 11'h0C8 (+25 °C) gives 16'h1900 and sample 11'h738 (−25 °C) gives 16'hE700.
- R5: `temp_valid_o` is 0 after reset and becomes 1 at the first accepted completion. It stays 1 until the next reset.
- R6: Each accepted completion raises `cmp_strobe_o` for exactly one cycle, at the same edge where `temp_reg_o` is loaded.
- R7: A `conv_done_i` pulse when no conversion is in flight is ignored. `temp_reg_o` is unchanged and no strobe is produced.
- R8: With `shutdown_i` = 1 (shutdown), no `conv_start_o` pulse is issued and the conversion in flight is abandoned. Any `conv_done_i` is then ignored, so `temp_reg_o` keeps its value and no strobe is produced.
- R9: The first clock edge at which `shutdown_i` is sampled 0 after being 1 raises `conv_start_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shutdown_i | input | 1 | Mode bit from configuration: 0 normal, 1 shutdown |
| conv_done_i | input | 1 | Converter completion pulse |
| conv_sample_i | input | 11 | Converter result, two's complement, 0.125 °C/LSB |
| conv_start_o | output | 1 | One-cycle request to begin a conversion |
| temp_reg_o | output | 16 | Temperature register, sample in bits [15:5] |
| temp_valid_o | output | 1 | Set once a first result has been stored |
| cmp_strobe_o | output | 1 | One-cycle pulse to the threshold comparator |

## Verification
The bench measures the start spacing to the exact cycle, so an off-by-one period counter shows up as a gap of `PERIOD_CYCLES`±1. It sends completion pulses when no conversion is in flight and while in shutdown. A design that accepted them would corrupt the held temperature or fire a spurious compare strobe. A negative sample is used to catch a wrong justification or a lost sign bit in the register layout. Return from shutdown must produce a start on the very next edge; a design that waited for the period timer would be visibly late.

// File: rtl/tcs_pkg.sv
// Package: shared widths and types for the conversion sequencer.
// Assumes an 11-bit converter result held left-justified in a 16-bit register.
package tcs_pkg;
    localparam int SAMPLE_W = 11;
    localparam int REG_W    = 16;
    localparam int PAD_W    = REG_W - SAMPLE_W;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [REG_W-1:0]    temp_reg_t;
endpackage

// File: rtl/tcs_scheduler.sv
// Module: conversion scheduler. Issues start pulses once per period while in
// normal mode, starts at once after reset or on leaving shutdown, and
// tracks whether a conversion is in flight so that only matching completions
// are accepted. Assumes PERIOD_CYCLES >= 2 and that the converter answers
// within one period.
module tcs_scheduler #(
    parameter int PERIOD_CYCLES = 20_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shutdown_i,
    input  logic done_i,
    output logic start_o,
    output logic accept_o
);
    localparam int TW = (PERIOD_CYCLES > 2) ? $clog2(PERIOD_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(PERIOD_CYCLES - 1);

    logic [TW-1:0] timer_q;
    logic          running_q;
    logic          busy_q;
    logic          launch;

    // Purpose: decide whether a new conversion begins this cycle.
    always_comb begin
        launch = !shutdown_i && (!running_q || (timer_q == LAST));
    end

    // Purpose: a completion counts only for a live conversion in normal mode.
    always_comb begin
        accept_o = done_i && busy_q && !shutdown_i;
    end

    // Purpose: period timer, start pulse, mode history and in-flight flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_q   <= '0;
            running_q <= 1'b0;
            busy_q    <= 1'b0;
            start_o   <= 1'b0;
        end else begin
            running_q <= !shutdown_i;
            start_o   <= launch;
            if (shutdown_i) begin
                timer_q <= '0;
                busy_q  <= 1'b0;
            end else if (launch) begin
                timer_q <= '0;
                busy_q  <= 1'b1;
            end else begin
                timer_q <= timer_q + 1'b1;
                if (accept_o) busy_q <= 1'b0;
            end
        end
    end

    // R8: shutdown sampled at an edge forbids a start pulse after it
    a_r8_no_start_in_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_i |=> !start_o);

    // R9: leaving shutdown restarts conversion at once
    a_r9_wake_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shutdown_i) |=> start_o);
endmodule

// File: rtl/tcs_result.sv
// Module: result register. Loads the accepted sample left-justified, keeps
// the sticky valid flag and emits the one-cycle compare strobe. Assumes the
// accept input is already qualified by mode and in-flight state.
module tcs_result
    import tcs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      accept_i,
    input  sample_t   sample_i,
    output temp_reg_t temp_o,
    output logic      valid_o,
    output logic      strobe_o
);
    // Purpose: capture on accepted completion, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            temp_o   <= '0;
            valid_o  <= 1'b0;
            strobe_o <= 1'b0;
        end else begin
            strobe_o <= accept_i;
            if (accept_i) begin
                temp_o  <= {sample_i, {PAD_W{1'b0}}};
                valid_o <= 1'b1;
            end
        end
    end

    // R4: the register moves only together with a compare strobe
    a_r4_temp_moves_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(temp_o) |-> strobe_o);

    // R5: valid never drops outside reset
    a_r5_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o);
endmodule

// File: rtl/temp_conv_sequencer.sv
// Module: top of the periodic conversion sequencer. Joins the scheduler
// to the result register. Assumes the converter stub pulses its done input
// for one cycle per requested conversion.
module temp_conv_sequencer
    import tcs_pkg::*;
#(
    parameter int PERIOD_CYCLES = 20_000_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shutdown_i,
    input  logic                conv_done_i,
    input  logic [SAMPLE_W-1:0] conv_sample_i,
    output logic                conv_start_o,
    output logic [REG_W-1:0]    temp_reg_o,
    output logic                temp_valid_o,
    output logic                cmp_strobe_o
);
    logic accept;

    tcs_scheduler #(.PERIOD_CYCLES(PERIOD_CYCLES)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .shutdown_i (shutdown_i),
        .done_i     (conv_done_i),
        .start_o    (conv_start_o),
        .accept_o   (accept)
    );

    tcs_result u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .sample_i (conv_sample_i),
        .temp_o   (temp_reg_o),
        .valid_o  (temp_valid_o),
        .strobe_o (cmp_strobe_o)
    );

    // R6: a compare strobe always follows a completion pulse from the converter
    a_r6_strobe_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_strobe_o |-> $past(conv_done_i));
endmodule

// File: tb/temp_conv_sequencer_bench.sv
module temp_conv_sequencer_bench;
    localparam int PERIOD = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        shutdown_i = 1'b0;
    logic        conv_done_i = 1'b0;
    logic [10:0] conv_sample_i = '0;
    logic        conv_start_o;
    logic [15:0] temp_reg_o;
    logic        temp_valid_o;
    logic        cmp_strobe_o;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    always #2.5 clk = ~clk;

    temp_conv_sequencer #(.PERIOD_CYCLES(PERIOD)) u_temp_conv_sequencer (
        .clk(clk), .rst_n(rst_n), .shutdown_i(shutdown_i),
        .conv_done_i(conv_done_i), .conv_sample_i(conv_sample_i),
        .conv_start_o(conv_start_o), .temp_reg_o(temp_reg_o),
        .temp_valid_o(temp_valid_o), .cmp_strobe_o(cmp_strobe_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #0.5;
    endtask

    // Wait until the next start pulse is seen (bounded).
    task automatic wait_start();
        for (int i = 0; i < 4*PERIOD; i++) begin
            if (conv_start_o) return;
            step();
        end
    endtask

    // Pulse done for one edge and check the capture.
    task automatic complete(input logic [10:0] s, input logic [15:0] exp, input string req);
        conv_sample_i = s;
        conv_done_i   = 1'b1;
        step();
        conv_done_i = 1'b0;
        chk({req, " temp"}, temp_reg_o, exp);
        chk("R6 strobe high", cmp_strobe_o, 1);
        chk("R5 valid set", temp_valid_o, 1);
        step();
        chk("R6 strobe one cycle", cmp_strobe_o, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        chk("R1 start", conv_start_o, 0);
        chk("R1 temp", temp_reg_o, 16'h0000);
        chk("R1 strobe", cmp_strobe_o, 0);
        chk("R5 valid after reset", temp_valid_o, 0);
    endtask

    task automatic t_first_start();
        rst_n = 1'b1;
        step();
        chk("R2 start after reset", conv_start_o, 1);
        step();
        chk("R2 start one cycle", conv_start_o, 0);
    endtask

    task automatic t_capture_and_period();
        int gap;
        repeat (3) step();
        complete(11'h0C8, 16'h1900, "R4 positive");
        // R3: measure the gap between two starts
        wait_start();
        gap = 0;
        step(); gap++;
        while (!conv_start_o && gap < 4*PERIOD) begin step(); gap++; end
        chk("R3 period", gap, PERIOD);
        step();
        complete(11'h738, 16'hE700, "R4 negative");
    endtask

    task automatic t_spurious();
        conv_sample_i = 11'h3FF;
        conv_done_i   = 1'b1;
        step();
        conv_done_i = 1'b0;
        chk("R7 temp held", temp_reg_o, 16'hE700);
        chk("R7 no strobe", cmp_strobe_o, 0);
    endtask

    task automatic t_shutdown();
        int starts = 0;
        wait_start();
        step();
        shutdown_i = 1'b1;
        step();
        conv_sample_i = 11'h100;
        conv_done_i   = 1'b1;
        step();
        conv_done_i = 1'b0;
        chk("R8 temp frozen", temp_reg_o, 16'hE700);
        chk("R8 no strobe", cmp_strobe_o, 0);
        for (int i = 0; i < 2*PERIOD; i++) begin
            if (conv_start_o) starts++;
            step();
        end
        chk("R8 no starts", starts, 0);
        chk("R8 temp still frozen", temp_reg_o, 16'hE700);
        chk("R5 valid held", temp_valid_o, 1);
    endtask

    task automatic t_wake();
        shutdown_i = 1'b0;
        step();
        chk("R9 start on wake", conv_start_o, 1);
        step();
        complete(11'h7FF, 16'hFFE0, "R4 after wake");
    endtask

    initial begin
        step();
        t_reset();
        t_first_start();
        t_capture_and_period();
        t_spurious();
        t_shutdown();
        t_wake();
        t_reset();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5.0);
        if (!ended) begin
            ended = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule